// File: doc/BRIEF.md
# Bit-Test Flag Accumulator

This execution-stage unit picks a single bit and folds it into one of the core's two status flags, carry (C) or zero (Z). The bit comes either from a 32-bit register operand or from a 64-wide vector of input pins. An index operand selects the bit, and the index may already have been rewritten by an earlier index-alteration prefix. The selected bit can be complemented before use. It then either overwrites the chosen flag or is combined with that flag's current value by AND, OR or XOR.

The unit holds C and Z as one-bit registers. Z takes the value of the selected bit itself and is not a result-is-zero test, so a selected 1 makes Z equal to 1. The flag-select encoding that names both flags at once belongs to another instruction group. When it reaches this unit, the unit raises a one-cycle illegal indication and leaves both flags untouched.

Top module: `bit_flag_accum`

## Requirements
- R1: While `rst` is high at a clock edge, `c_o`, `z_o` and `illegal_o` become 0.
- R2: With `src_pin_i`=0 the source bit is `reg_word_i[index_i[4:0]]`, and `index_i[5]` has no effect.
- R3: With `src_pin_i`=1 the source bit is `pins_i[index_i]`, covering all 64 pins.
- R4: With `invert_i`=1 the source bit is complemented before the flag operation.
- R5: `op_i` encodes 00 = load, 01 = AND, 10 = OR, 11 = XOR of the bit with the target flag's current value.
- R6: With Z as the target, a load of a bit of 1 gives Z=1 and a load of a bit of 0 gives Z=0.
- R7: `wc_i`=1 with `wz_i`=0 targets C, and `wz_i`=1 with `wc_i`=0 targets Z. The flag that is not targeted keeps its value.
- R8: A flag changes only on the clock edge at which `valid_i` is high. With `valid_i` low, the flags hold.
- R9: With `valid_i`, `wc_i` and `wz_i` all high, `illegal_o` is 1 for the following cycle and C and Z are unchanged. In every other cycle `illegal_o` is 0.
- R10: With `valid_i` high and neither flag selected, nothing changes and `illegal_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation issue strobe |
| src_pin_i | input | 1 | 1 = pin source, 0 = register source |
| invert_i | input | 1 | Complement the selected bit |
| op_i | input | 2 | Flag operation: 00 load, 01 AND, 10 OR, 11 XOR |
| index_i | input | 6 | Bit or pin index |
| reg_word_i | input | 32 | Register operand |
| pins_i | input | 64 | Input pin vector |
| wc_i | input | 1 | Select carry as target |
| wz_i | input | 1 | Select zero flag as target |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| illegal_o | output | 1 | Both-flag encoding seen on the previous issue |

## Verification
The flags are the unit's only state, so a wrong selection, a missing inversion or a wrong combine shows up on `c_o` or `z_o` one cycle after the issuing edge. Because later AND, OR and XOR operations fold new bits into the stored flag, an error in the stored value keeps showing on later results. A wrong target decode appears either as a change on the flag that was not selected or as a flag that fails to move. Each of these is visible on the first result after the faulty operation. A mishandled both-flag encoding shows up at once as a flag change or as a missing `illegal_o` pulse.

// File: rtl/bflag_pkg.sv
package bflag_pkg;
  typedef enum logic [1:0] {
    FOP_LOAD = 2'b00,
    FOP_AND  = 2'b01,
    FOP_OR   = 2'b10,
    FOP_XOR  = 2'b11
  } flag_op_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/bit_pick.sv
module bit_pick #(
  parameter int REG_W = 32,
  parameter int PIN_W = 64,
  localparam int REG_IW = $clog2(REG_W),
  localparam int IDX_W = (PIN_W > REG_W) ? $clog2(PIN_W) : REG_IW
) (
  input  logic             src_pin,
  input  logic             invert,
  input  logic [IDX_W-1:0] index,
  input  logic [REG_W-1:0] reg_word,
  input  logic [PIN_W-1:0] pins,
  output logic             bit_o
);
  logic reg_bit;
  logic pin_bit;

  // register bits use only the low index bits
  assign reg_bit = reg_word[index[REG_IW-1:0]];
  assign pin_bit = pins[index];

  always_comb begin
    bit_o = (src_pin ? pin_bit : reg_bit) ^ invert;
  end
endmodule

// File: rtl/flag_merge.sv
module flag_merge
  import bflag_pkg::*;
(
  input  flag_op_e op,
  input  logic     cur,
  input  logic     bit_i,
  output logic     nxt
);
  always_comb begin
    unique case (op)
      FOP_LOAD: nxt = bit_i;
      FOP_AND:  nxt = cur & bit_i;
      FOP_OR:   nxt = cur | bit_i;
      FOP_XOR:  nxt = cur ^ bit_i;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bit_flag_accum.sv
module bit_flag_accum
  import bflag_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int PIN_W = 64,
  localparam int IDX_W = (PIN_W > REG_W) ? $clog2(PIN_W) : $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             src_pin_i,
  input  logic             invert_i,
  input  logic [1:0]       op_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic [REG_W-1:0] reg_word_i,
  input  logic [PIN_W-1:0] pins_i,
  input  logic             wc_i,
  input  logic             wz_i,
  output logic             c_o,
  output logic             z_o,
  output logic             illegal_o
);
  logic                 sel_bit;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_nxt;
  logic [NUM_FLAGS-1:0] target;
  logic                 both_sel;
  logic                 illegal_q;

  bit_pick #(.REG_W(REG_W), .PIN_W(PIN_W)) u_pick (
    .src_pin (src_pin_i),
    .invert  (invert_i),
    .index   (index_i),
    .reg_word(reg_word_i),
    .pins    (pins_i),
    .bit_o   (sel_bit)
  );

  assign both_sel       = wc_i & wz_i;
  assign target[FLAG_C] = wc_i & ~wz_i;
  assign target[FLAG_Z] = wz_i & ~wc_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    flag_merge u_merge (
      .op   (flag_op_e'(op_i)),
      .cur  (flag_q[g]),
      .bit_i(sel_bit),
      .nxt  (flag_nxt[g])
    );

    always_ff @(posedge clk) begin
      if (rst)
        flag_q[g] <= 1'b0;
      else if (valid_i && target[g])
        flag_q[g] <= flag_nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) illegal_q <= 1'b0;
    else     illegal_q <= valid_i & both_sel;
  end

  assign c_o       = flag_q[FLAG_C];
  assign z_o       = flag_q[FLAG_Z];
  assign illegal_o = illegal_q;

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(c_o) && $stable(z_o)));

  // R9
  illegal_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && wc_i && wz_i) |=> (illegal_o && $stable(c_o) && $stable(z_o)));

  // R7
  z_untouched_on_c_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && wc_i && !wz_i) |=> $stable(z_o));

  // R7
  c_untouched_on_z_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && wz_i && !wc_i) |=> $stable(c_o));

  // R6
  z_load_gets_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && wz_i && !wc_i && op_i == 2'b00) |=> (z_o == $past(sel_bit)));

  // R10
  no_target_no_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !wc_i && !wz_i) |=> (!illegal_o && $stable(c_o) && $stable(z_o)));
endmodule

// File: tb/bit_flag_accum_tb.sv
module bit_flag_accum_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic        src_pin_i = 1'b0;
  logic        invert_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [5:0]  index_i = '0;
  logic [31:0] reg_word_i = '0;
  logic [63:0] pins_i = '0;
  logic        wc_i = 1'b0;
  logic        wz_i = 1'b0;
  logic        c_o, z_o, illegal_o;

  int checks = 0;
  int fails = 0;
  logic mc = 1'b0, mz = 1'b0;

  typedef struct {
    logic  c;
    logic  z;
    logic  ill;
    string req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  bit_flag_accum u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .src_pin_i(src_pin_i),
    .invert_i(invert_i), .op_i(op_i), .index_i(index_i),
    .reg_word_i(reg_word_i), .pins_i(pins_i), .wc_i(wc_i), .wz_i(wz_i),
    .c_o(c_o), .z_o(z_o), .illegal_o(illegal_o)
  );

  function automatic logic apply_op(logic [1:0] op, logic cur, logic b);
    case (op)
      2'b00:   return b;
      2'b01:   return cur & b;
      2'b10:   return cur | b;
      default: return cur ^ b;
    endcase
  endfunction

  task automatic issue(input logic sp, input logic inv, input logic [1:0] op,
                       input logic [5:0] idx, input logic wc, input logic wz,
                       input string req);
    logic b;
    logic ill;
    exp_t e;
    @(negedge clk);
    valid_i = 1'b1; src_pin_i = sp; invert_i = inv; op_i = op;
    index_i = idx; wc_i = wc; wz_i = wz;
    b = (sp ? pins_i[idx] : reg_word_i[idx[4:0]]) ^ inv;
    ill = wc & wz;
    if (!ill && wc) mc = apply_op(op, mc, b);
    if (!ill && wz) mz = apply_op(op, mz, b);
    @(posedge clk);
    e.c = mc; e.z = mz; e.ill = ill; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input string req);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b0;
    wc_i = 1'b1; op_i = 2'b00; invert_i = 1'b1;
    @(posedge clk);
    e.c = mc; e.z = mz; e.ill = 1'b0; e.req = req;
    q.push_back(e);
  endtask

  task automatic check_now(input string req, input logic c, input logic z, input logic ill);
    checks++;
    if (c_o !== c || z_o !== z || illegal_o !== ill) begin
      fails++;
      $display("FAIL %s: got c=%b z=%b ill=%b expected c=%b z=%b ill=%b",
               req, c_o, z_o, illegal_o, c, z, ill);
    end
  endtask

  // monitor: compares one queued result per cycle
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check_now(e.req, e.c, e.z, e.ill);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now("R1", 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    reg_word_i = 32'hA5F0_0F5A;
    pins_i     = 64'h8000_0001_F00D_0000;

    // R2 register source loads into C, bit 1 = 1, bit 0 = 0
    issue(0, 0, 2'b00, 6'd1, 1, 0, "R2");
    issue(0, 0, 2'b00, 6'd0, 1, 0, "R2");
    // R2 index bit 5 ignored: 33 -> bit 1
    issue(0, 0, 2'b00, 6'd33, 1, 0, "R2");
    // R6 Z load of 1 and of 0
    issue(0, 0, 2'b00, 6'd31, 0, 1, "R6");
    issue(0, 0, 2'b00, 6'd2, 0, 1, "R6");
    // R3 pins above 31
    issue(1, 0, 2'b00, 6'd63, 0, 1, "R3");
    issue(1, 0, 2'b00, 6'd62, 1, 0, "R3");
    issue(1, 0, 2'b00, 6'd32, 1, 0, "R3");
    issue(1, 0, 2'b00, 6'd0, 0, 1, "R3");
    // R4 inversion
    issue(1, 1, 2'b00, 6'd0, 0, 1, "R4");
    issue(0, 1, 2'b00, 6'd1, 1, 0, "R4");
    // R5 combine ops on C
    issue(0, 0, 2'b10, 6'd1, 1, 0, "R5");
    issue(0, 0, 2'b01, 6'd1, 1, 0, "R5");
    issue(0, 0, 2'b01, 6'd0, 1, 0, "R5");
    issue(0, 0, 2'b11, 6'd1, 1, 0, "R5");
    issue(0, 0, 2'b11, 6'd1, 1, 0, "R5");
    issue(1, 0, 2'b10, 6'd4, 0, 1, "R5");
    issue(1, 1, 2'b11, 6'd20, 0, 1, "R5");
    // R7 target isolation with both flags differing
    issue(0, 0, 2'b00, 6'd3, 1, 0, "R7");
    issue(0, 0, 2'b00, 6'd5, 0, 1, "R7");
    // R9 both selected: no change, illegal pulse
    issue(0, 1, 2'b00, 6'd5, 1, 1, "R9");
    issue(0, 0, 2'b11, 6'd4, 1, 1, "R9");
    // R10 none selected
    issue(1, 0, 2'b00, 6'd63, 0, 0, "R10");
    // R8 idle cycles with inputs that would change C
    idle("R8");
    idle("R8");
    idle("R9");

    wait (q.size() == 0);
    // R1 reset mid-run after setting both flags
    issue(1, 0, 2'b00, 6'd63, 1, 0, "R1");
    issue(1, 0, 2'b00, 6'd63, 0, 1, "R1");
    idle("R1");
    wait (q.size() == 0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_now("R1", 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    mc = 1'b0; mz = 1'b0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule